// File: doc/BRIEF.md
# Interleaved Memory Bank Conflict Scheduler

This block sits between a stream of vector element addresses and a group of memory banks that are addressed independently. The low bits of each address pick the bank, and the upper bits are passed to that bank as the row. Each bank stays occupied for a fixed number of clocks after it accepts an access. The scheduler sends at most one element to the banks per clock. It holds the stream whenever the bank of the element at the head is still occupied. It never moves a later element ahead of a stalled one.

Every accepted element is numbered in the order it was accepted. That number comes back on a completion stream exactly one bank latency after the element was accepted, so completions always leave in the order the elements went in. A cycle counter and a stall counter are exposed on ports. They let the stall cost of a given access pattern be measured directly: unit stride when there are enough banks, strides that share a factor with the bank count, and strides that keep landing on one bank.

Top module: `bsched_top`

## Requirements
- R1: The bank of an element is its address modulo NBANKS (the low log2(NBANKS) address bits). On acceptance, bit b of `bank_req` is set for that bank b, and `bank_row` carries the address shifted right by log2(NBANKS).
- R2: `bank_req` has at most one bit set, and it is nonzero only in a cycle where `in_valid` and `in_ready` are both high.
- R3: After a bank accepts an element, that bank refuses new elements for the next LAT-1 cycles and accepts again exactly LAT cycles after the earlier acceptance.
- R4: Elements to different banks are accepted in consecutive cycles without a stall.
- R5: A unit-stride stream, or any stride that visits at least LAT distinct banks before it returns to one, is accepted at one element per clock with zero stalls.
- R6: A stride that is a multiple of NBANKS is accepted at one element every LAT cycles. N elements cost (N-1)*(LAT-1) stall cycles.
- R7: Each element produces one completion pulse (`cmp_valid`) exactly LAT cycles after its acceptance cycle. `cmp_tag` equals its element number (acceptance order, counted from reset, modulo 2^TAG_W).
- R8: While the head element waits on a busy bank, `in_ready` stays low and no request goes to any bank, even a free one.
- R9: `cycle_cnt` counts clocks since reset. `stall_cnt` counts clocks in which `in_valid` is high and `in_ready` is low.
- R10: During and right after reset, `in_ready` is high, `bank_req` is zero, `cmp_valid` is low, and both counters are zero.
- R11: A stride that visits k distinct banks with k < LAT accepts k elements, then stalls LAT-k cycles, and repeats. For N elements (N a multiple of k) this costs (N/k-1)*(LAT-k) stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Head element address is valid |
| in_addr | input | ADDR_W | Head element address |
| in_ready | output | 1 | Head element is accepted this cycle |
| bank_req | output | NBANKS | One-hot request to the selected bank |
| bank_row | output | ADDR_W-log2(NBANKS) | Row address within the selected bank |
| cmp_valid | output | 1 | Completion pulse |
| cmp_tag | output | TAG_W | Element number of the completing access |
| cycle_cnt | output | CNT_W | Clocks since reset |
| stall_cnt | output | CNT_W | Clocks with the head element held |

## Verification
The bench runs a unit-stride stream and a stride-2 stream (four banks in rotation, equal to the latency). Both must run without a single stall. It also runs a stride-4 stream, which alternates between two banks and so must stall two cycles after every pair. A stride-8 stream stays on one bank and must pay the full latency on every element. Together, the stall counts and the spacing between acceptances separate a correct per-bank timer from timers that are off by one, shared between banks, or tied to the wrong address bits. A short two-element case to one bank, and another to two different banks, isolates the head-of-line hold from the independent-bank overlap. A monitor checks the tag and the exact arrival cycle of every completion throughout the run.

// File: rtl/bsched_pkg.sv
// Shared definitions for the bank conflict scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package bsched_pkg;
    // Default geometry of the bank array
    localparam int unsigned DEF_NBANKS = 8;
    localparam int unsigned DEF_LAT    = 4;

    // Occupancy state reported by each bank timer
    typedef enum logic {
        BANK_FREE = 1'b0,
        BANK_BUSY = 1'b1
    } bank_state_e;
endpackage

// File: rtl/bsched_bank_timer.sv
// Occupancy timer for one memory bank.
// On a load it counts LAT-1 further busy cycles, so a bank that accepts
// an access in cycle t is free again in cycle t+LAT.
// Assumes: load is only asserted while the bank is free; LAT >= 1.
module bsched_bank_timer
    import bsched_pkg::*;
#(
    parameter int unsigned LAT = DEF_LAT
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    output bank_state_e state
);
    localparam int unsigned TW = (LAT > 1) ? $clog2(LAT) : 1;

    logic [TW-1:0] remain_q;

    // Load the remaining busy time on access, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= TW'(LAT - 1);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // Report occupancy
    always_comb begin
        state = (remain_q != '0) ? BANK_BUSY : BANK_FREE;
    end
endmodule

// File: rtl/bsched_cmp_pipe.sv
// Fixed-depth completion delay line.
// An element entering in cycle t appears at the output in cycle t+LAT,
// so completions leave in the order they entered.
// Assumes: LAT >= 1.
module bsched_cmp_pipe #(
    parameter int unsigned LAT   = 4,
    parameter int unsigned TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_vld,
    output logic [TAG_W-1:0] out_tag
);
    logic [LAT-1:0]   vld_q;
    logic [TAG_W-1:0] tag_q [LAT];

    // Shift the valid bit and tag one stage per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < LAT; i++) begin
                tag_q[i] <= '0;
            end
        end else begin
            vld_q[0] <= in_vld;
            tag_q[0] <= in_tag;
            for (int i = 1; i < LAT; i++) begin
                vld_q[i] <= vld_q[i-1];
                tag_q[i] <= tag_q[i-1];
            end
        end
    end

    // The last stage drives the completion stream
    always_comb begin
        out_vld = vld_q[LAT-1];
        out_tag = tag_q[LAT-1];
    end
endmodule

// File: rtl/bsched_stats.sv
// Free-running cycle counter and head-of-line stall counter.
// Assumes: counters wrap silently at 2^CNT_W.
module bsched_stats #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    output logic [CNT_W-1:0] cycle_cnt,
    output logic [CNT_W-1:0] stall_cnt
);
    // Count every clock after reset
    always_ff @(posedge clk) begin
        if (!rst_n) cycle_cnt <= '0;
        else        cycle_cnt <= cycle_cnt + 1'b1;
    end

    // Count clocks in which the head element is held
    always_ff @(posedge clk) begin
        if (!rst_n)     stall_cnt <= '0;
        else if (stall) stall_cnt <= stall_cnt + 1'b1;
    end
endmodule

// File: rtl/bsched_top.sv
// Interleaved memory bank conflict scheduler.
// Accepts one element address per clock when the addressed bank is free,
// sends a one-hot request with row address to that bank, holds the head
// element while its bank is busy, and reports numbered completions LAT
// cycles after acceptance in acceptance order.
// Assumes: NBANKS is a power of two and at least 2; LAT >= 1;
// the source holds in_addr stable while in_valid is high and in_ready is low.
module bsched_top
    import bsched_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned NBANKS = DEF_NBANKS,
    parameter int unsigned LAT    = DEF_LAT,
    parameter int unsigned TAG_W  = 8,
    parameter int unsigned CNT_W  = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    input  logic [ADDR_W-1:0]                     in_addr,
    output logic                                  in_ready,
    output logic [NBANKS-1:0]                     bank_req,
    output logic [ADDR_W-$clog2(NBANKS)-1:0]      bank_row,
    output logic                                  cmp_valid,
    output logic [TAG_W-1:0]                      cmp_tag,
    output logic [CNT_W-1:0]                      cycle_cnt,
    output logic [CNT_W-1:0]                      stall_cnt
);
    localparam int unsigned BANK_W = $clog2(NBANKS);

    logic [BANK_W-1:0] head_bank;
    logic [NBANKS-1:0] busy;
    logic              fire;
    logic [TAG_W-1:0]  elem_q;

    // Split the head address into bank select and row
    always_comb begin
        head_bank = in_addr[BANK_W-1:0];
        bank_row  = in_addr[ADDR_W-1:BANK_W];
    end

    // One occupancy timer per bank
    for (genvar g = 0; g < NBANKS; g++) begin : g_bank
        bank_state_e st;
        bsched_bank_timer #(.LAT(LAT)) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (fire && (head_bank == BANK_W'(g))),
            .state (st)
        );
        assign busy[g] = (st == BANK_BUSY);
    end

    // Accept the head element only when its own bank is free
    always_comb begin
        in_ready = !busy[head_bank];
        fire     = in_valid && in_ready;
    end

    // Steer the accepted element to its bank
    always_comb begin
        bank_req = '0;
        if (fire) bank_req[head_bank] = 1'b1;
    end

    // Number elements in acceptance order
    always_ff @(posedge clk) begin
        if (!rst_n)    elem_q <= '0;
        else if (fire) elem_q <= elem_q + 1'b1;
    end

    bsched_cmp_pipe #(.LAT(LAT), .TAG_W(TAG_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (fire),
        .in_tag  (elem_q),
        .out_vld (cmp_valid),
        .out_tag (cmp_tag)
    );

    bsched_stats #(.CNT_W(CNT_W)) u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (in_valid && !in_ready),
        .cycle_cnt (cycle_cnt),
        .stall_cnt (stall_cnt)
    );
endmodule

// File: rtl/bsched_top_chk.sv
// Property checker for bsched_top, attached with bind.
// Keeps its own per-bank spacing counters and an outstanding count.
// Assumes: same parameters as the bound instance.
module bsched_top_chk #(
    parameter int unsigned NBANKS = 8,
    parameter int unsigned LAT    = 4,
    parameter int unsigned CNT_W  = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic [$clog2(NBANKS)-1:0]  head_bank,
    input logic [NBANKS-1:0]          bank_req,
    input logic                       cmp_valid,
    input logic [CNT_W-1:0]           cycle_cnt,
    input logic [CNT_W-1:0]           stall_cnt
);
    localparam int unsigned SW = $clog2(LAT + 1) + 1;

    logic [SW-1:0] outstanding_q;

    // Track elements accepted but not yet completed
    always_ff @(posedge clk) begin
        if (!rst_n) outstanding_q <= '0;
        else outstanding_q <= outstanding_q + SW'(|bank_req) - SW'(cmp_valid);
    end

    p_onehot_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_req));

    p_req_needs_handshake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_req) |-> (in_valid && in_ready));

    p_bank_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> bank_req[head_bank]);

    p_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding_q <= SW'(LAT));

    p_cmp_has_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> (outstanding_q != '0));

    p_cycle_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cycle_cnt == $past(cycle_cnt) + 1'b1);

    p_stall_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> stall_cnt == $past(stall_cnt) + 1'b1);

    p_no_stall_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !in_ready) |=> $stable(stall_cnt));

    // Per-bank spacing between accepted accesses
    for (genvar g = 0; g < NBANKS; g++) begin : g_space
        logic [SW-1:0] since_q;

        // Count cycles since this bank last accepted, saturating at LAT
        always_ff @(posedge clk) begin
            if (!rst_n)                   since_q <= SW'(LAT);
            else if (bank_req[g])         since_q <= SW'(1);
            else if (since_q < SW'(LAT))  since_q <= since_q + 1'b1;
        end

        p_bank_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
            bank_req[g] |-> since_q >= SW'(LAT));
    end
endmodule

bind bsched_top bsched_top_chk #(
    .NBANKS (NBANKS),
    .LAT    (LAT),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .head_bank (in_addr[BANK_W-1:0]),
    .bank_req  (bank_req),
    .cmp_valid (cmp_valid),
    .cycle_cnt (cycle_cnt),
    .stall_cnt (stall_cnt)
);

// File: tb/bsched_top_bench.sv
// Directed bench for bsched_top: one task per access pattern.
module bsched_top_bench;
    localparam int ADDR_W = 16;
    localparam int NBANKS = 8;
    localparam int LAT    = 4;
    localparam int TAG_W  = 8;
    localparam int CNT_W  = 32;
    localparam int ROW_W  = ADDR_W - 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic              in_ready;
    logic [NBANKS-1:0] bank_req;
    logic [ROW_W-1:0]  bank_row;
    logic              cmp_valid;
    logic [TAG_W-1:0]  cmp_tag;
    logic [CNT_W-1:0]  cycle_cnt;
    logic [CNT_W-1:0]  stall_cnt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int elem_n = 0;
    int cmp_n = 0;
    int issue_time [256];

    bsched_top #(
        .ADDR_W(ADDR_W), .NBANKS(NBANKS), .LAT(LAT), .TAG_W(TAG_W), .CNT_W(CNT_W)
    ) u_bsched_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_ready(in_ready), .bank_req(bank_req), .bank_row(bank_row),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
        .cycle_cnt(cycle_cnt), .stall_cnt(stall_cnt)
    );

    always #5 clk = ~clk;

    // Clocks since reset release, as seen by the bench
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Completion monitor: order, tag and exact arrival cycle (R7)
    always @(negedge clk) begin
        if (rst_n && cmp_valid) begin
            check(cmp_n < elem_n, "R7", "completion without issue", cmp_n, elem_n);
            check(cmp_tag == TAG_W'(cmp_n), "R7", "completion tag", cmp_tag, cmp_n % 256);
            check(cyc == issue_time[cmp_n % 256] + LAT, "R7", "completion cycle",
                  cyc, issue_time[cmp_n % 256] + LAT);
            cmp_n++;
        end
    end

    // Drive n elements base, base+stride, ...; check selection, stalls and spacing
    task automatic run_stream(input string req, input int base, input int stride,
                              input int n, input int exp_stall, input int exp_gap);
        logic [CNT_W-1:0] s0;
        int times [64];
        logic [ADDR_W-1:0] a;
        repeat (LAT + 1) @(negedge clk);
        s0 = stall_cnt;
        for (int i = 0; i < n; i++) begin
            a = ADDR_W'(base + i * stride);
            in_valid = 1'b1;
            in_addr  = a;
            #1;
            while (!in_ready) begin
                check(bank_req == '0, "R8", "request while head held", bank_req, 0);
                @(negedge clk);
                #1;
            end
            check(bank_req == NBANKS'(1) << a[2:0], "R1", "bank select",
                  bank_req, 1 << a[2:0]);
            check(bank_row == a[ADDR_W-1:3], "R1", "bank row", bank_row, a[ADDR_W-1:3]);
            issue_time[elem_n % 256] = cyc;
            times[i] = cyc;
            elem_n++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        #1;
        check(stall_cnt - s0 == CNT_W'(exp_stall), req, "stall count",
              stall_cnt - s0, exp_stall);
        if (exp_gap > 0) begin
            for (int i = 1; i < n; i++) begin
                check(times[i] - times[i-1] == exp_gap, req, "acceptance spacing",
                      times[i] - times[i-1], exp_gap);
            end
        end
    endtask

    task automatic test_reset();
        #1;
        check(in_ready == 1'b1, "R10", "ready in reset", in_ready, 1);
        check(bank_req == '0, "R10", "no request in reset", bank_req, 0);
        check(cmp_valid == 1'b0, "R10", "no completion in reset", cmp_valid, 0);
        check(cycle_cnt == '0, "R10", "cycle count in reset", cycle_cnt, 0);
        check(stall_cnt == '0, "R10", "stall count in reset", stall_cnt, 0);
    endtask

    task automatic test_unit_stride();
        run_stream("R5", 0, 1, 16, 0, 1);
    endtask

    task automatic test_stride_two();
        run_stream("R5", 32, 2, 8, 0, 1);
    endtask

    task automatic test_same_bank();
        run_stream("R6", 64, 8, 5, (5 - 1) * (LAT - 1), LAT);
    endtask

    task automatic test_two_bank_stride();
        run_stream("R11", 128, 4, 8, (8 / 2 - 1) * (LAT - 2), 0);
    endtask

    task automatic test_independent_banks();
        run_stream("R4", 3, 2, 2, 0, 1);
    endtask

    task automatic test_head_hold();
        run_stream("R3", 16, 8, 2, LAT - 1, LAT);
    endtask

    task automatic test_drain_and_counters();
        repeat (LAT + 2) @(negedge clk);
        check(cmp_n == elem_n, "R7", "all completions seen", cmp_n, elem_n);
        check(cycle_cnt == CNT_W'(cyc), "R9", "cycle counter", cycle_cnt, cyc);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_unit_stride();
        test_stride_two();
        test_same_bank();
        test_two_bank_stride();
        test_independent_banks();
        test_head_hold();
        test_drain_and_counters();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule